// File: doc/BRIEF.md
# I2C Slave Front End with Strap-Selected Address

This block is the bus-facing half of an I2C target device. It runs on a system clock that oversamples SCL and SDA. It detects START, REPEATED START and STOP conditions, receives the address byte, and acknowledges the address and every written data byte. Written bytes go to user logic as one-cycle strobes. For a read, the block asks the user logic for one byte and shifts it out MSB first. The SDA output is an open-drain pull-down enable: 1 pulls the line low and 0 releases it.

The upper five address bits are fixed by a parameter. The lower two come from a single strap pin, which can be tied low, tied high, or wired to SDA or to SCL. The block works out which connection is present by comparing the synchronised strap with the synchronised bus lines. It freezes that result after a set number of SCL edges following reset. A STOP that falls inside the same SCL high period as the START it follows is not legal, so the block ignores it.

Top module: `i2c_strap_slave`

## Requirements
- R1: The device address is {ADDR_HI = 5'b10010, sel[1:0]}, with sel = 00 when the strap is low, 01 when it is high, 10 when it follows SDA and 11 when it follows SCL. The selection is frozen once LOCK_EDGES SCL edges have been seen after reset.
- R2: The first byte after a START is received MSB first, with bit 0 as R/W (0 = write, 1 = read). On an address match, sda_oe_o is 1 throughout the ninth SCL high period.
- R3: Each data byte received in a write is presented on wr_data_o with a one-cycle wr_stb_o after its eighth SCL rising edge, and is acknowledged during the ninth clock.
- R4: A STOP (SDA rising while SCL is high) is honoured at any point of a transfer. It releases SDA and returns the block to idle, and SCL clocking without a new START then gives no acknowledge and no strobe.
- R5: A STOP inside the same SCL high period as the preceding START is ignored, and reception of the address byte continues.
- R6: sda_oe_o changes only while SCL is low. After an acknowledge of a write or a non-read address it returns to 0 right after the ninth SCL falling edge.
- R7: After a non-matching address, sda_oe_o stays 0 and no strobe is issued until the next START.
- R8: A REPEATED START restarts address reception, so consecutive writes work with or without a STOP between them.
- R9: After a read address is acknowledged, rd_req_o pulses for one cycle at the rising edge of the acknowledge clock. rd_data_i is captured at that clock's falling edge and driven MSB first. Exactly one byte is sent per read address, and SDA is then released regardless of the master's acknowledge until the next START or STOP.
- R10: While reset is held and after its release, sda_oe_o, wr_stb_o and rd_req_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL as seen on the bus |
| sda_i | input | 1 | SDA as seen on the bus (wired-AND) |
| strap_i | input | 1 | Address strap pin |
| sda_oe_o | output | 1 | SDA pull-down enable |
| wr_stb_o | output | 1 | Written-byte strobe |
| wr_data_o | output | 8 | Written byte |
| rd_req_o | output | 1 | Read byte request |
| rd_data_i | input | 8 | Byte to transmit |

## Verification
Every bus line passes through two synchroniser stages and one edge register before the control logic acts on it. The SDA enable and both strobes therefore respond within three system clocks of the SCL edge that triggers them. The bench model of the master holds each quarter of an SCL bit for six clocks and samples acknowledges and read data in the middle of the SCL high period, well after the response has settled. Strobes are logged on every falling clock edge and compared with the bytes the bench sent. A separate monitor flags any change of the SDA enable while the master holds SCL high.

// File: rtl/i2c_strap_pkg.sv
package i2c_strap_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;
  localparam int SEL_W  = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_DATA,
    ST_WR_ACK,
    ST_RD_DATA,
    ST_WAIT
  } slv_state_e;
endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic strap_i,
  output logic scl_s_o,
  output logic sda_s_o,
  output logic strap_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic sda_edge_o,
  output logic start_o,
  output logic stop_o
);
  localparam int LINES = 3;

  logic [LINES-1:0] raw, synced;
  logic scl_p, sda_p, start_hi;
  logic stop_raw;

  assign raw = {strap_i, sda_i, scl_i};

  for (genvar g = 0; g < LINES; g++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain <= '1;
      else         chain <= {chain[SYNC_STAGES-2:0], raw[g]};
    end
    assign synced[g] = chain[SYNC_STAGES-1];
  end

  assign scl_s_o   = synced[0];
  assign sda_s_o   = synced[1];
  assign strap_s_o = synced[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s_o;
      sda_p <= sda_s_o;
    end
  end

  assign scl_rise_o = scl_s_o & ~scl_p;
  assign scl_fall_o = ~scl_s_o & scl_p;
  assign sda_edge_o = sda_s_o ^ sda_p;
  assign start_o    = scl_s_o & scl_p & sda_p & ~sda_s_o;
  assign stop_raw   = scl_s_o & scl_p & ~sda_p & sda_s_o;

  // START opens a high period in which a STOP is not legal
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       start_hi <= 1'b0;
    else if (start_o)  start_hi <= 1'b1;
    else if (!scl_s_o) start_hi <= 1'b0;
  end

  assign stop_o = stop_raw & ~start_hi;

  AST_NO_STOP_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(start_o) && scl_s_o && $past(scl_s_o)) |-> !stop_o) // R5
    else $error("stop accepted inside start high period");
endmodule

// File: rtl/i2c_strap_decode.sv
module i2c_strap_decode
  import i2c_strap_pkg::*;
#(
  parameter int LOCK_EDGES = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_s_i,
  input  logic             sda_s_i,
  input  logic             strap_s_i,
  input  logic             scl_edge_i,
  input  logic             sda_edge_i,
  output logic [SEL_W-1:0] sel_o
);
  localparam int CNT_W = $clog2(LOCK_EDGES + 1);
  localparam logic [CNT_W-1:0] LOCK_AT = CNT_W'(LOCK_EDGES);
  localparam logic [CNT_W-1:0] MIN_SCL = CNT_W'(2);

  logic [CNT_W-1:0] scl_cnt;
  logic [1:0]       sda_cnt;
  logic             mis_scl, mis_sda, locked;
  logic [SEL_W-1:0] sel_q, sel_d;

  assign locked = (scl_cnt == LOCK_AT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_cnt <= '0;
      sda_cnt <= '0;
      mis_scl <= 1'b0;
      mis_sda <= 1'b0;
    end else if (!locked) begin
      if (scl_edge_i) scl_cnt <= scl_cnt + 1'b1;
      if (sda_edge_i && sda_cnt != 2'd3) sda_cnt <= sda_cnt + 1'b1;
      if (strap_s_i != scl_s_i) mis_scl <= 1'b1;
      if (strap_s_i != sda_s_i) mis_sda <= 1'b1;
    end
  end

  always_comb begin
    if (!mis_scl && scl_cnt >= MIN_SCL)   sel_d = 2'b11;
    else if (!mis_sda && sda_cnt != 2'd0) sel_d = 2'b10;
    else                                  sel_d = {1'b0, strap_s_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sel_q <= '0;
    else if (!locked) sel_q <= sel_d;
  end

  assign sel_o = sel_q;

  AST_SEL_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked && $past(locked)) |-> $stable(sel_q)) // R1
    else $error("strap selection moved after lock");
endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import i2c_strap_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_s_i,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  output logic              sda_oe_o,
  output logic              wr_stb_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              rd_req_o,
  input  logic [BYTE_W-1:0] rd_data_i
);
  localparam logic [2:0] LAST_BIT = 3'(BYTE_W - 1);

  slv_state_e        state;
  logic [2:0]        bit_cnt;
  logic [BYTE_W-1:0] rx_sr, tx_sr;
  logic              byte_done, is_read, oe_q;
  logic [BYTE_W-1:0] rx_next;

  assign rx_next = {rx_sr[BYTE_W-2:0], sda_s_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state     <= ST_IDLE;
      bit_cnt   <= '0;
      rx_sr     <= '0;
      tx_sr     <= '0;
      byte_done <= 1'b0;
      is_read   <= 1'b0;
      oe_q      <= 1'b0;
      wr_stb_o  <= 1'b0;
      wr_data_o <= '0;
      rd_req_o  <= 1'b0;
    end else begin
      wr_stb_o <= 1'b0;
      rd_req_o <= 1'b0;
      if (start_i) begin
        state     <= ST_ADDR;
        bit_cnt   <= '0;
        byte_done <= 1'b0;
        oe_q      <= 1'b0;
      end else if (stop_i) begin
        state     <= ST_IDLE;
        byte_done <= 1'b0;
        oe_q      <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_WR_DATA: begin
            if (scl_rise_i) begin
              rx_sr   <= rx_next;
              bit_cnt <= bit_cnt + 1'b1;
              if (bit_cnt == LAST_BIT) begin
                byte_done <= 1'b1;
                if (state == ST_WR_DATA) begin
                  wr_stb_o  <= 1'b1;
                  wr_data_o <= rx_next;
                end
              end
            end else if (scl_fall_i && byte_done) begin
              byte_done <= 1'b0;
              if (state == ST_WR_DATA) begin
                oe_q  <= 1'b1;
                state <= ST_WR_ACK;
              end else if (rx_sr[BYTE_W-1:1] == own_addr_i) begin
                oe_q    <= 1'b1;
                is_read <= rx_sr[0];
                state   <= ST_ADDR_ACK;
              end else begin
                state <= ST_WAIT;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_rise_i && is_read) rd_req_o <= 1'b1;
            if (scl_fall_i) begin
              bit_cnt <= '0;
              if (is_read) begin
                tx_sr <= rd_data_i;
                oe_q  <= ~rd_data_i[BYTE_W-1];
                state <= ST_RD_DATA;
              end else begin
                oe_q  <= 1'b0;
                state <= ST_WR_DATA;
              end
            end
          end
          ST_WR_ACK: begin
            if (scl_fall_i) begin
              oe_q    <= 1'b0;
              bit_cnt <= '0;
              state   <= ST_WR_DATA;
            end
          end
          ST_RD_DATA: begin
            if (scl_fall_i) begin
              if (bit_cnt == LAST_BIT) begin
                oe_q  <= 1'b0;
                state <= ST_WAIT;
              end else begin
                tx_sr   <= {tx_sr[BYTE_W-2:0], 1'b0};
                oe_q    <= ~tx_sr[BYTE_W-2];
                bit_cnt <= bit_cnt + 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o = oe_q;

  AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_q != $past(oe_q)) |-> (!$past(scl_s_i) || $past(start_i) || $past(stop_i))) // R6
    else $error("sda enable changed with scl high");
  AST_WAIT_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_WAIT) |-> !oe_q) // R7
    else $error("sda driven while ignoring bus");
  AST_STOP_IDLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !start_i) |=> (state == ST_IDLE && !oe_q)) // R4
    else $error("stop did not return to idle");
  AST_WR_STB_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |=> !wr_stb_o) // R3
    else $error("write strobe longer than one cycle");
  AST_RD_REQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |=> !rd_req_o) // R9
    else $error("read request longer than one cycle");
endmodule

// File: rtl/i2c_strap_slave.sv
module i2c_strap_slave
  import i2c_strap_pkg::*;
#(
  parameter logic [4:0] ADDR_HI     = 5'b10010,
  parameter int         LOCK_EDGES  = 32,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              strap_i,
  output logic              sda_oe_o,
  output logic              wr_stb_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              rd_req_o,
  input  logic [BYTE_W-1:0] rd_data_i
);
  logic scl_s, sda_s, strap_s;
  logic scl_rise, scl_fall, sda_edge, start_det, stop_det;
  logic [SEL_W-1:0]  sel;
  logic [ADDR_W-1:0] own_addr;

  i2c_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .strap_i    (strap_i),
    .scl_s_o    (scl_s),
    .sda_s_o    (sda_s),
    .strap_s_o  (strap_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .sda_edge_o (sda_edge),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  i2c_strap_decode #(.LOCK_EDGES(LOCK_EDGES)) u_strap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_s_i    (scl_s),
    .sda_s_i    (sda_s),
    .strap_s_i  (strap_s),
    .scl_edge_i (scl_rise | scl_fall),
    .sda_edge_i (sda_edge),
    .sel_o      (sel)
  );

  assign own_addr = {ADDR_HI, sel};

  i2c_slave_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_s_i    (scl_s),
    .sda_s_i    (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .own_addr_i (own_addr),
    .sda_oe_o   (sda_oe_o),
    .wr_stb_o   (wr_stb_o),
    .wr_data_o  (wr_data_o),
    .rd_req_o   (rd_req_o),
    .rd_data_i  (rd_data_i)
  );

  AST_RESET_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!sda_oe_o && !wr_stb_o && !rd_req_o)) // R10
    else $error("outputs active out of reset");
endmodule

// File: tb/i2c_strap_slave_bench.sv
`timescale 1ns/1ps
module i2c_strap_slave_bench;
  localparam int Q = 6;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n;
  logic       scl_m, sda_m, strap;
  logic [1:0] strap_sel;
  logic       sda_oe, wr_stb, rd_req;
  logic [7:0] wr_data, rd_data;
  wire        sda_bus = sda_m & ~sda_oe;

  int vectors = 0, miscompares = 0;
  bit done = 0;
  int wr_n = 0, rd_n = 0, oe_viol = 0;
  logic [7:0] wr_log [0:63];
  logic scl_q = 1'b1, oe_q = 1'b0;

  always_comb begin
    case (strap_sel)
      2'd0: strap = 1'b0;
      2'd1: strap = 1'b1;
      2'd2: strap = sda_bus;
      default: strap = scl_m;
    endcase
  end

  i2c_strap_slave u_i2c_strap_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .strap_i(strap),
    .sda_oe_o(sda_oe), .wr_stb_o(wr_stb), .wr_data_o(wr_data),
    .rd_req_o(rd_req), .rd_data_i(rd_data)
  );

  always @(negedge clk) begin
    if (wr_stb) begin wr_log[wr_n % 64] = wr_data; wr_n++; end
    if (rd_req) rd_n++;
    if (rst_n && scl_m && scl_q && sda_oe != oe_q) oe_viol++;
    scl_q = scl_m;
    oe_q  = sda_oe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] dev_addr(input logic [1:0] sel);
    return {5'b10010, sel};
  endfunction

  task automatic qw(); repeat (Q) @(negedge clk); endtask

  task automatic m_start();
    sda_m = 1; scl_m = 1; qw(); sda_m = 0; qw(); scl_m = 0; qw();
  endtask
  task automatic m_rstart();
    sda_m = 1; qw(); scl_m = 1; qw(); sda_m = 0; qw(); scl_m = 0; qw();
  endtask
  task automatic m_stop();
    sda_m = 0; qw(); scl_m = 1; qw(); sda_m = 1; qw();
  endtask
  task automatic m_bit(input logic b);
    sda_m = b; qw(); scl_m = 1; qw(); qw(); scl_m = 0; qw();
  endtask
  // sends a byte, returns 1 if acknowledged and the enable state after the 9th fall
  task automatic m_send(input logic [7:0] b, output bit ack, output logic oe_after);
    for (int i = 7; i >= 0; i--) m_bit(b[i]);
    sda_m = 1; qw(); scl_m = 1; qw(); ack = !sda_bus; qw(); scl_m = 0; qw();
    oe_after = sda_oe;
  endtask
  task automatic m_read(output logic [7:0] b, input bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1; qw(); scl_m = 1; qw(); b[i] = sda_bus; qw(); scl_m = 0; qw();
    end
    sda_m = !ack; qw(); scl_m = 1; qw(); qw(); scl_m = 0; qw();
  endtask

  task automatic do_reset(input logic [1:0] sel);
    strap_sel = sel; scl_m = 1; sda_m = 1; rd_data = 8'h00;
    rst_n = 0; repeat (5) @(negedge clk);
    chk(sda_oe == 0 && wr_stb == 0 && rd_req == 0, "R10 reset quiet", {sda_oe, wr_stb, rd_req}, 0);
    rst_n = 1; repeat (5) @(negedge clk);
    chk(sda_oe == 0 && wr_stb == 0 && rd_req == 0, "R10 after reset", {sda_oe, wr_stb, rd_req}, 0);
  endtask

  task automatic write_burst(input logic [1:0] sel, input int nbytes, input bit use_start);
    bit ack; logic oe_a; logic [7:0] b; int base;
    if (use_start) m_start(); else m_rstart();
    m_send({dev_addr(sel), 1'b0}, ack, oe_a);
    chk(ack, "R1 R2 address ack", ack, 1);
    chk(oe_a == 0, "R6 release after ack", oe_a, 0);
    for (int k = 0; k < nbytes; k++) begin
      b = 8'($urandom);
      base = wr_n;
      m_send(b, ack, oe_a);
      chk(ack, "R3 data ack", ack, 1);
      chk(wr_n == base + 1 && wr_log[base % 64] == b, "R3 write strobe data",
          wr_log[base % 64], b);
      chk(oe_a == 0, "R6 release after data ack", oe_a, 0);
    end
  endtask

  task automatic run_config(input logic [1:0] sel);
    bit ack; logic oe_a; logic [7:0] b, rv; int base, rbase; logic [1:0] other;
    do_reset(sel);
    // first transaction also settles the strap classification
    write_burst(sel, 1 + ($urandom % 3), 1);
    m_stop();
    // R8: two writes joined by a repeated start
    write_burst(sel, 2, 1);
    base = wr_n;
    write_burst(sel, 1, 0);
    chk(wr_n == base + 1, "R8 write after repeated start", wr_n - base, 1);
    m_stop();
    // R7: other address
    other = sel ^ 2'(1 + ($urandom % 3));
    base = wr_n;
    m_start();
    m_send({dev_addr(other), 1'b0}, ack, oe_a);
    chk(!ack, "R7 foreign address nack", ack, 0);
    m_send(8'h00, ack, oe_a);
    chk(!ack && wr_n == base, "R7 foreign data ignored", wr_n - base, 0);
    m_stop();
    // R9: single-byte read
    rv = 8'($urandom);
    rd_data = rv;
    rbase = rd_n;
    m_start();
    m_send({dev_addr(sel), 1'b1}, ack, oe_a);
    chk(ack, "R2 read address ack", ack, 1);
    chk(rd_n == rbase + 1, "R9 read request pulse", rd_n - rbase, 1);
    m_read(b, ($urandom % 2) == 1);
    chk(b == rv, "R9 read data", b, rv);
    m_read(b, 0);
    chk(b == 8'hFF && rd_n == rbase + 1, "R9 one byte per read", b, 8'hFF);
    m_stop();
    // R5: stop inside the start high period is ignored
    base = wr_n;
    sda_m = 1; scl_m = 1; qw(); sda_m = 0; qw(); sda_m = 1; qw(); scl_m = 0; qw();
    m_send({dev_addr(sel), 1'b0}, ack, oe_a);
    chk(ack, "R5 early stop ignored", ack, 1);
    b = 8'($urandom);
    m_send(b, ack, oe_a);
    chk(wr_n == base + 1 && wr_log[base % 64] == b, "R5 write after early stop",
        wr_log[base % 64], b);
    // R4: stop mid-byte, then clocking without start
    m_bit(1'b1); m_bit(1'b0); m_bit(1'b1);
    m_stop();
    chk(sda_oe == 0, "R4 released at stop", sda_oe, 0);
    base = wr_n;
    scl_m = 0; qw();
    m_send({dev_addr(sel), 1'b0}, ack, oe_a);
    chk(!ack, "R4 no ack without start", ack, 0);
    m_send(8'h5A, ack, oe_a);
    chk(!ack && wr_n == base, "R4 no strobe without start", wr_n - base, 0);
    m_stop();
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'h1DCA_7E55);
    for (int s = 0; s < 4; s++) run_config(2'(s));
    // extra random-address probes on the last configuration
    for (int n = 0; n < 6; n++) begin
      bit ack; logic oe_a; logic [6:0] a;
      a = 7'($urandom);
      m_start();
      m_send({a, 1'b0}, ack, oe_a);
      chk(ack == (a == dev_addr(2'd3)), "R1 R7 random address", ack, a == dev_addr(2'd3));
      m_stop();
    end
    chk(oe_viol == 0, "R6 enable stable while scl high", oe_viol, 0);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      vectors++; miscompares++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule